// File: doc/BRIEF.md
# UART Command Frame Transmitter

This block turns one command, a 32-bit period value and an 8-bit on/off pattern, into a fixed eight-byte frame on a single asynchronous serial output line. A one-cycle start request launches the frame. When the request is accepted, the block copies the period, the pattern and a 3-bit line-rate code into its own registers. It then sends the two sync bytes, the period with its most significant byte first, the pattern byte and a closing trailer byte. Each byte follows the previous one with no gap.

The block holds its own bit-period counter. The length of one bit is worked out from the selected baud rate and the nominal system clock period, which is a parameter. A busy output covers the whole frame. A one-cycle done pulse marks the end of the last stop bit. The line rests high whenever no frame is in flight.

Top module: `cmdFrameTx`

## Requirements
- R1: While reset is held low, and until the first start is accepted, txLine is 1, busy is 0 and done is 0. The reset input rstN is asynchronous and active low.
- R2: Each byte occupies 10 bit periods on txLine. The first is a start bit at 0. The next eight carry the data, bit 0 first and bit 7 last. The tenth is a stop bit at 1.
- R3: One bit period lasts (1e9 / baud) / CLK_PERIOD_NS clock cycles, truncating after each division. Rate code 0 selects 300 baud, 1 selects 1200, 2 selects 2400, 3 selects 9600, 4 selects 19200 and 5 selects 115200. Codes 6 and 7 select 9600.
- R4: The eight frame bytes leave in this order: 0x0F, 0xAB, periodIn[31:24], periodIn[23:16], periodIn[15:8], periodIn[7:0], patternIn, 0xA5.
- R5: The bytes of one frame follow each other without idle time, so a frame lasts exactly 80 bit periods.
- R6: When startIn is 1 and busy is 0 at a clock edge, the frame is accepted. After that edge busy is 1 and txLine is 0, the start bit of byte 0.
- R7: startIn has no effect while busy is 1. The period, pattern and rate code are sampled only at the accepting edge, so later changes to them do not alter the frame in flight.
- R8: The edge that ends the last stop bit, 80 bit periods after the accepting edge, drops busy to 0 and raises done for exactly one cycle.
- R9: Whenever busy is 0, txLine is 1.
- R10: If startIn is still 1 in the cycle where done is high, a new frame is accepted at the next edge. The new frame uses the operands present at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| startIn | input | 1 | Request to send one frame |
| periodIn | input | 32 | Period value carried in frame bytes 2 to 5 |
| patternIn | input | 8 | On/off pattern carried in frame byte 6 |
| rateIn | input | 3 | Line-rate code |
| txLine | output | 1 | Serial output, high when idle |
| busy | output | 1 | High while a frame is being sent |
| done | output | 1 | One-cycle pulse at the end of a frame |

## Verification
The cycle that ends a frame can coincide with a new start request. At that edge busy is still high, so the request must be refused; one cycle later busy is low and the same request must be taken. The bench provokes this by holding startIn high from the middle of a frame through its end. It expects done to be high for exactly one cycle with busy low, then busy high again with txLine low in the following cycle. It also decodes the second frame at mid-bit to confirm that it carries the operands present at the re-accepting edge. A second overlap, a start request arriving in the middle of a byte, is judged by checking the line level of every cycle of the frame against the ideal waveform.

// File: rtl/cftx_pkg.sv
package cftx_pkg;

  localparam int unsigned NS_PER_SEC   = 1_000_000_000;
  localparam int unsigned SLOWEST_BAUD = 300;
  localparam int unsigned FRAME_BYTES  = 8;
  localparam int unsigned SLOT_BITS    = 10;
  localparam int unsigned SEL_W        = $clog2(FRAME_BYTES);
  localparam int unsigned SLOT_W       = $clog2(SLOT_BITS);

  localparam logic [7:0] SYNC_FIRST  = 8'h0F;
  localparam logic [7:0] SYNC_SECOND = 8'hAB;
  localparam logic [7:0] TRAILER     = 8'hA5;

  // Rate code to baud; unused codes fall back to 9600
  function automatic int unsigned baudOf(input logic [2:0] code);
    case (code)
      3'd0:    baudOf = 300;
      3'd1:    baudOf = 1200;
      3'd2:    baudOf = 2400;
      3'd3:    baudOf = 9600;
      3'd4:    baudOf = 19200;
      3'd5:    baudOf = 115200;
      default: baudOf = 9600;
    endcase
  endfunction

  typedef enum logic {ST_IDLE, ST_SEND} txState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic             capture;   // accept a frame, load byte 0
    logic             shiftBit;  // advance to the next bit of a byte
    logic             nextByte;  // load the byte named by byteSel
    logic             finish;    // last stop bit ended
    logic [SEL_W-1:0] byteSel;
  } cftxStrobes_t;

endpackage

// File: rtl/cftx_rate.sv
module cftx_rate
  import cftx_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_NS = 20,
  parameter int unsigned CNT_W         = 18
) (
  input  logic [2:0]       rateCode,
  output logic [CNT_W-1:0] bitLen
);

  localparam int unsigned CODES = 8;

  logic [CNT_W-1:0] lenTable [CODES];

  for (genvar i = 0; i < CODES; i++) begin : g_len
    localparam int unsigned CYC = NS_PER_SEC / baudOf(3'(i)) / CLK_PERIOD_NS;
    assign lenTable[i] = CNT_W'(CYC);
  end

  assign bitLen = lenTable[rateCode];

endmodule

// File: rtl/cftx_datapath.sv
module cftx_datapath
  import cftx_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_NS = 20,
  parameter int unsigned CNT_W         = 18
) (
  input  logic         clk,
  input  logic         rstN,
  input  cftxStrobes_t stb,
  input  logic         busy,
  input  logic [31:0]  periodIn,
  input  logic [7:0]   patternIn,
  input  logic [2:0]   rateIn,
  output logic         bitEnd,
  output logic         txLine
);

  logic [31:0]      periodReg;
  logic [7:0]       patternReg;
  logic [CNT_W-1:0] bitLenReg;
  logic [CNT_W-1:0] bitLenNew;
  logic [CNT_W-1:0] bitCnt;
  logic [8:0]       shifter;   // {stop, data[7:0]} still to send
  logic             txReg;
  logic [7:0]       selByte;

  cftx_rate #(
    .CLK_PERIOD_NS(CLK_PERIOD_NS),
    .CNT_W        (CNT_W)
  ) u_rate (
    .rateCode(rateIn),
    .bitLen  (bitLenNew)
  );

  always_comb begin
    case (stb.byteSel)
      SEL_W'(0): selByte = SYNC_FIRST;
      SEL_W'(1): selByte = SYNC_SECOND;
      SEL_W'(2): selByte = periodReg[31:24];
      SEL_W'(3): selByte = periodReg[23:16];
      SEL_W'(4): selByte = periodReg[15:8];
      SEL_W'(5): selByte = periodReg[7:0];
      SEL_W'(6): selByte = patternReg;
      default:   selByte = TRAILER;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      periodReg  <= '0;
      patternReg <= '0;
      bitLenReg  <= '0;
    end else if (stb.capture) begin
      periodReg  <= periodIn;
      patternReg <= patternIn;
      bitLenReg  <= bitLenNew;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      bitCnt <= '0;
    else if (!busy || stb.capture || stb.shiftBit || stb.nextByte)
      bitCnt <= '0;
    else
      bitCnt <= bitCnt + CNT_W'(1);
  end

  assign bitEnd = busy && (bitCnt == bitLenReg - CNT_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shifter <= '1;
      txReg   <= 1'b1;
    end else if (stb.capture || stb.nextByte) begin
      shifter <= {1'b1, selByte};
      txReg   <= 1'b0;
    end else if (stb.shiftBit) begin
      shifter <= {1'b1, shifter[8:1]};
      txReg   <= shifter[0];
    end else if (stb.finish) begin
      txReg   <= 1'b1;
    end
  end

  assign txLine = txReg;

endmodule

// File: rtl/cftx_ctrl.sv
module cftx_ctrl
  import cftx_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         startIn,
  input  logic         bitEnd,
  output cftxStrobes_t stb,
  output logic         busy,
  output logic         done
);

  localparam logic [SLOT_W-1:0] LAST_BIT  = SLOT_W'(SLOT_BITS - 1);
  localparam logic [SEL_W-1:0]  LAST_BYTE = SEL_W'(FRAME_BYTES - 1);

  txState_t          state;
  logic [SLOT_W-1:0] bitIdx;
  logic [SEL_W-1:0]  byteIdx;

  always_comb begin
    stb = '0;
    if (state == ST_IDLE) begin
      if (startIn) begin
        stb.capture = 1'b1;
        stb.byteSel = '0;
      end
    end else if (bitEnd) begin
      if (bitIdx != LAST_BIT) begin
        stb.shiftBit = 1'b1;
      end else if (byteIdx != LAST_BYTE) begin
        stb.nextByte = 1'b1;
        stb.byteSel  = byteIdx + SEL_W'(1);
      end else begin
        stb.finish = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      bitIdx  <= '0;
      byteIdx <= '0;
      done    <= 1'b0;
    end else begin
      done <= stb.finish;
      if (stb.capture) begin
        state   <= ST_SEND;
        bitIdx  <= '0;
        byteIdx <= '0;
      end else if (stb.shiftBit) begin
        bitIdx  <= bitIdx + SLOT_W'(1);
      end else if (stb.nextByte) begin
        bitIdx  <= '0;
        byteIdx <= byteIdx + SEL_W'(1);
      end else if (stb.finish) begin
        state   <= ST_IDLE;
      end
    end
  end

  assign busy = (state == ST_SEND);

endmodule

// File: rtl/cmdFrameTx.sv
module cmdFrameTx
  import cftx_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_NS = 20
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        startIn,
  input  logic [31:0] periodIn,
  input  logic [7:0]  patternIn,
  input  logic [2:0]  rateIn,
  output logic        txLine,
  output logic        busy,
  output logic        done
);

  localparam int unsigned MAX_BIT_CYC = NS_PER_SEC / SLOWEST_BAUD / CLK_PERIOD_NS;
  localparam int unsigned CNT_W       = $clog2(MAX_BIT_CYC + 1);

  cftxStrobes_t stb;
  logic         bitEnd;

  cftx_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .startIn(startIn),
    .bitEnd (bitEnd),
    .stb    (stb),
    .busy   (busy),
    .done   (done)
  );

  cftx_datapath #(
    .CLK_PERIOD_NS(CLK_PERIOD_NS),
    .CNT_W        (CNT_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .busy     (busy),
    .periodIn (periodIn),
    .patternIn(patternIn),
    .rateIn   (rateIn),
    .bitEnd   (bitEnd),
    .txLine   (txLine)
  );

endmodule

// File: rtl/cftx_chk.sv
module cftx_chk (
  input logic clk,
  input logic rstN,
  input logic startIn,
  input logic busy,
  input logic done,
  input logic txLine
);

  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> txLine) else $error("idle line not high"); // R9

  AST_START_BIT_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> !txLine) else $error("frame did not open with start bit"); // R6

  AST_ACCEPT_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && startIn) |=> busy) else $error("start while idle not accepted"); // R6

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done) else $error("done longer than one cycle"); // R8

  AST_DONE_AT_FALL: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $fell(busy)) else $error("done without busy falling"); // R8

  AST_FALL_HAS_DONE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done) else $error("busy fell without done"); // R8

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> txLine) else $error("line low at done"); // R2

endmodule

bind cmdFrameTx cftx_chk u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .startIn(startIn),
  .busy   (busy),
  .done   (done),
  .txLine (txLine)
);

// File: tb/tb_cmdFrameTx.sv
`timescale 1ns/1ps
module tb_cmdFrameTx;

  localparam int unsigned NOMINAL_NS = 2000;  // small config: short bit periods

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startIn = 1'b0;
  logic [31:0] periodIn = '0;
  logic [7:0]  patternIn = '0;
  logic [2:0]  rateIn = '0;
  logic        txLine, busy, done;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  cmdFrameTx #(.CLK_PERIOD_NS(NOMINAL_NS)) dut (
    .clk(clk), .rstN(rstN), .startIn(startIn), .periodIn(periodIn),
    .patternIn(patternIn), .rateIn(rateIn), .txLine(txLine),
    .busy(busy), .done(done)
  );

  function automatic int bitCyc(input logic [2:0] rc);
    int baud;
    case (rc)
      3'd0: baud = 300;
      3'd1: baud = 1200;
      3'd2: baud = 2400;
      3'd3: baud = 9600;
      3'd4: baud = 19200;
      3'd5: baud = 115200;
      default: baud = 9600;
    endcase
    return 1000000000 / baud / NOMINAL_NS;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Called at the first negedge after the accepting edge (t = 0).
  task automatic watchFrame(input logic [31:0] per, input logic [7:0] pat,
                            input logic [2:0] rc, input bit hold,
                            input logic [31:0] nPer, input logic [7:0] nPat,
                            input logic [2:0] nRc);
    int n = bitCyc(rc);
    logic [7:0] expB [8];
    logic bits [80];
    int bad = 0;
    int busyBad = 0;
    expB[0] = 8'h0F; expB[1] = 8'hAB;
    expB[2] = per[31:24]; expB[3] = per[23:16];
    expB[4] = per[15:8];  expB[5] = per[7:0];
    expB[6] = pat;        expB[7] = 8'hA5;
    for (int t = 0; t < 80 * n; t++) begin
      int b = t / n;
      int k = b % 10;
      logic lvl;
      lvl = (k == 0) ? 1'b0 : (k == 9) ? 1'b1 : expB[b / 10][k - 1];
      if (txLine !== lvl) bad++;
      if (busy !== 1'b1 || done !== 1'b0) busyBad++;
      if (t % n == n / 2) bits[b] = txLine;
      if (t == 5 * n) begin
        // R7: disturb operands and request again mid-frame
        periodIn = ~per; patternIn = ~pat; rateIn = rc ^ 3'd2; startIn = 1'b1;
      end
      if (t == 5 * n + 1 && !hold) startIn = 1'b0;
      if (t == 80 * n - 1) begin
        periodIn = nPer; patternIn = nPat; rateIn = nRc;
      end
      @(negedge clk);
    end
    for (int j = 0; j < 8; j++) begin
      logic [7:0] got;
      for (int d = 0; d < 8; d++) got[d] = bits[10 * j + 1 + d];
      check(got == expB[j], "R4", $sformatf("rate %0d byte %0d value", rc, j), got, expB[j]);
      check(bits[10 * j] == 1'b0 && bits[10 * j + 9] == 1'b1, "R2",
            $sformatf("rate %0d byte %0d start/stop", rc, j),
            {bits[10 * j], bits[10 * j + 9]}, 2'b01);
    end
    check(bad == 0, "R3", $sformatf("rate %0d cycles off ideal waveform (R5 R7)", rc), bad, 0);
    check(busyBad == 0, "R7", $sformatf("rate %0d busy/done during frame", rc), busyBad, 0);
    check(done === 1'b1 && busy === 1'b0 && txLine === 1'b1, "R8",
          $sformatf("rate %0d end {done,busy,tx}", rc), {done, busy, txLine}, 3'b101);
  endtask

  task automatic kick(input logic [31:0] per, input logic [7:0] pat, input logic [2:0] rc);
    @(negedge clk);
    check(busy === 1'b0 && txLine === 1'b1, "R9", "idle before start", {busy, txLine}, 2'b01);
    periodIn = per; patternIn = pat; rateIn = rc; startIn = 1'b1;
    @(negedge clk);
    startIn = 1'b0;
    check(busy === 1'b1 && txLine === 1'b0, "R6", "accept {busy,tx}", {busy, txLine}, 2'b10);
  endtask

  task automatic afterFrame();
    @(negedge clk);
    check(done === 1'b0 && busy === 1'b0 && txLine === 1'b1, "R8",
          "one cycle after done {done,busy,tx}", {done, busy, txLine}, 3'b001);
  endtask

  initial begin
    logic [2:0] codes [7];
    codes = '{3'd5, 3'd4, 3'd3, 3'd6, 3'd7, 3'd2, 3'd1};
    repeat (3) @(negedge clk);
    check(txLine === 1'b1 && busy === 1'b0 && done === 1'b0, "R1", "in reset",
          {txLine, busy, done}, 3'b100);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(txLine === 1'b1 && busy === 1'b0 && done === 1'b0, "R1", "after reset",
          {txLine, busy, done}, 3'b100);

    for (int i = 0; i < 7; i++) begin
      logic [31:0] per;
      logic [7:0]  pat;
      per = 32'h1357_9BDF ^ (32'h0101_0101 * i) ^ {i[7:0], 24'h80_4020};
      pat = 8'h5A ^ i[7:0];
      kick(per, pat, codes[i]);
      watchFrame(per, pat, codes[i], 1'b0, 32'h0, 8'h0, 3'd0);
      afterFrame();
    end

    // R10: start held high across the end of a frame
    kick(32'hDEAD_0042, 8'hC3, 3'd5);
    watchFrame(32'hDEAD_0042, 8'hC3, 3'd5, 1'b1, 32'h0011_2233, 8'h3C, 3'd4);
    @(negedge clk);
    startIn = 1'b0;
    check(busy === 1'b1 && txLine === 1'b0 && done === 1'b0, "R10",
          "re-accept {busy,tx,done}", {busy, txLine, done}, 3'b100);
    watchFrame(32'h0011_2233, 8'h3C, 3'd4, 1'b0, 32'h0, 8'h0, 3'd0);
    afterFrame();

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R8 watchdog: actual=timeout expected=all frames done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule